// File: doc/BRIEF.md
# Global Shutter Frame Transfer Sequencer

This block produces the three pixel-array control lines that move an exposed charge from each photodiode into its in-pixel storage node. The three lines are a memory-bias line, a precharge line and a sample line, and the move happens during the frame overhead interval. A single-cycle start strobe begins the interval. Three programmable lengths, all counted in clock cycles, shape the interval: the whole overhead window, the precharge pulse and the sample pulse.

The pulses always nest the same way. The bias line drops while precharge and sample rise together. Precharge ends first, so sampling finishes in the remaining sample-high time. The bias line is restored when sample ends. Once the overhead window has run out, and the bias line has had that time to settle, a readout-enable level rises together with a one-cycle done strobe.

Lengths are captured and made legal when a start is accepted. A start that arrives during a running interval is dropped. An overhead length of zero selects the built-in default of 659 cycles, which is 3.2 µs at 206 MHz.

Top module: `fxfer_seq`

## Requirements
- R1: After reset, and whenever idle, mem_bias_o=1, precharge_o=0, sample_o=0, busy_o=0 and done_o=0. rd_en_o is 0 after reset.
- R2: When start_i=1 is sampled with busy_o=0, all of the following hold in the next cycle: mem_bias_o=0, precharge_o=1, sample_o=1 and busy_o=1.
- R3: precharge_o stays high for exactly P cycles, starting in the first cycle of the interval. P is the captured precharge length. precharge_o is never high while sample_o is low.
- R4: sample_o stays high for exactly S cycles (S > P), starting in the first cycle of the interval. mem_bias_o is low exactly while sample_o is high inside the interval, so it returns high in the first cycle that sample_o is low.
- R5: busy_o stays high for exactly T cycles (T > S). In the cycle right after the last busy cycle, rd_en_o and done_o both rise. done_o lasts one cycle.
- R6: rd_en_o stays high from that point until the next accepted start. It is low in the first cycle of the next interval.
- R7: A start_i pulse while busy_o=1 has no effect on the running interval. Neither do changes to the length inputs during the interval.
- R8: Lengths are made legal at start. P = min(max(pre_len_i,1), 2^W-3). S = min(max(smp_len_i,P+1), 2^W-2). T = max(O,S+1), where O is the overhead value defined in R9.
- R9: O equals ovh_len_i when ovh_len_i is nonzero. When ovh_len_i is zero, O is the default overhead of 659 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one frame transfer |
| ovh_len_i | input | W | Overhead window length in cycles; 0 selects the default |
| pre_len_i | input | W | Precharge pulse length in cycles |
| smp_len_i | input | W | Sample pulse length in cycles |
| mem_bias_o | output | 1 | Storage-node bias line, low during transfer |
| precharge_o | output | 1 | Storage-node precharge pulse |
| sample_o | output | 1 | Storage-node sample pulse |
| busy_o | output | 1 | High for the whole overhead window |
| rd_en_o | output | 1 | Readout may start; held until next start |
| done_o | output | 1 | One-cycle strobe when readout enable rises |

## Verification
The assertions check the following on every cycle:
- the pulse nesting (precharge only inside sample, bias low only while sample is high);
- the entry state after an accepted start;
- the single-cycle done strobe together with readout enable at the end of busy;
- the legality of the captured lengths;
- that the captured lengths and the step count are undisturbed during a running interval.

Only the bench scenarios show the exact pulse widths and overhead lengths against independently computed values. The same holds for each clamping case, the default overhead selection, and that readout enable persists until the next start.

// File: rtl/fxfer_pkg.sv
package fxfer_pkg;

  // Clamp v into [lo, hi]; lo wins if the range is empty.
  function automatic int unsigned fx_clamp(int unsigned v, int unsigned lo, int unsigned hi);
    int unsigned r;
    r = (v > hi) ? hi : v;
    if (r < lo) r = lo;
    return r;
  endfunction

  // A pulse of length len covers interval steps 0 .. len-1.
  function automatic logic fx_covers(int unsigned step, int unsigned len);
    return step < len;
  endfunction

endpackage

// File: rtl/fxfer_cfg_latch.sv
module fxfer_cfg_latch #(
  parameter int unsigned W       = 12,
  parameter int unsigned DEF_OVH = 659
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] ovh_raw_i,
  input  logic [W-1:0] pre_raw_i,
  input  logic [W-1:0] smp_raw_i,
  output logic [W-1:0] ovh_q_o,
  output logic [W-1:0] pre_q_o,
  output logic [W-1:0] smp_q_o
);
  import fxfer_pkg::*;

  localparam int unsigned MAXV = (32'd1 << W) - 32'd1;

  int unsigned ovh_sel, p_leg, s_leg, t_leg;

  always_comb begin
    ovh_sel = (ovh_raw_i == '0) ? DEF_OVH : 32'(ovh_raw_i);
    p_leg   = fx_clamp(32'(pre_raw_i), 1, MAXV - 2);
    s_leg   = fx_clamp(32'(smp_raw_i), p_leg + 1, MAXV - 1);
    t_leg   = fx_clamp(ovh_sel, s_leg + 1, MAXV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovh_q_o <= W'(DEF_OVH);
      pre_q_o <= W'(1);
      smp_q_o <= W'(2);
    end else if (load_i) begin
      ovh_q_o <= W'(t_leg);
      pre_q_o <= W'(p_leg);
      smp_q_o <= W'(s_leg);
    end
  end

  // R8: captured lengths obey 1 <= P < S < T
  a_r8_legal_order: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pre_q_o >= W'(1)) && (smp_q_o > pre_q_o) && (ovh_q_o > smp_q_o));

endmodule

// File: rtl/fxfer_step_ctr.sv
module fxfer_step_ctr #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] step_q_o,
  output logic         busy_q_o,
  output logic         last_o
);

  assign last_o = busy_q_o && (step_q_o == len_i - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q_o <= '0;
      busy_q_o <= 1'b0;
    end else if (go_i) begin
      step_q_o <= '0;
      busy_q_o <= 1'b1;
    end else if (last_o) begin
      busy_q_o <= 1'b0;
    end else if (busy_q_o) begin
      step_q_o <= step_q_o + W'(1);
    end
  end

  // R7: a running interval advances by exactly one step each cycle
  a_r7_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q_o && !last_o) |=> busy_q_o && (step_q_o == $past(step_q_o) + W'(1)));

endmodule

// File: rtl/fxfer_seq.sv
module fxfer_seq #(
  parameter int unsigned W       = 12,
  parameter int unsigned DEF_OVH = 659
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] ovh_len_i,
  input  logic [W-1:0] pre_len_i,
  input  logic [W-1:0] smp_len_i,
  output logic         mem_bias_o,
  output logic         precharge_o,
  output logic         sample_o,
  output logic         busy_o,
  output logic         rd_en_o,
  output logic         done_o
);
  import fxfer_pkg::*;

  logic [W-1:0] ovh_q, pre_q, smp_q, step_q;
  logic         busy_q, seq_last, start_acc;
  int unsigned  next_step;

  assign start_acc = start_i && !busy_q;
  assign busy_o    = busy_q;
  assign next_step = 32'(step_q) + 32'd1;

  fxfer_cfg_latch #(.W(W), .DEF_OVH(DEF_OVH)) cfg_u (
    .clk(clk), .rst_n(rst_n), .load_i(start_acc),
    .ovh_raw_i(ovh_len_i), .pre_raw_i(pre_len_i), .smp_raw_i(smp_len_i),
    .ovh_q_o(ovh_q), .pre_q_o(pre_q), .smp_q_o(smp_q)
  );

  fxfer_step_ctr #(.W(W)) ctr_u (
    .clk(clk), .rst_n(rst_n), .go_i(start_acc), .len_i(ovh_q),
    .step_q_o(step_q), .busy_q_o(busy_q), .last_o(seq_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_bias_o  <= 1'b1;
      precharge_o <= 1'b0;
      sample_o    <= 1'b0;
      rd_en_o     <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_acc) begin
        mem_bias_o  <= 1'b0;
        precharge_o <= 1'b1;
        sample_o    <= 1'b1;
        rd_en_o     <= 1'b0;
      end else if (seq_last) begin
        mem_bias_o  <= 1'b1;
        precharge_o <= 1'b0;
        sample_o    <= 1'b0;
        rd_en_o     <= 1'b1;
        done_o      <= 1'b1;
      end else if (busy_q) begin
        precharge_o <= fx_covers(next_step, 32'(pre_q));
        sample_o    <= fx_covers(next_step, 32'(smp_q));
        mem_bias_o  <= !fx_covers(next_step, 32'(smp_q));
      end
    end
  end

  // R2: entry state one cycle after an accepted start
  a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !mem_bias_o && precharge_o && sample_o && busy_o && !rd_en_o);
  // R3: precharge nests inside sample
  a_r3_pre_in_smp: assert property (@(posedge clk) disable iff (!rst_n)
    precharge_o |-> sample_o);
  // R4: bias is low exactly while sample is high
  a_r4_bias_vs_smp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_bias_o == !sample_o);
  // R5: end of busy brings readout enable and the done strobe
  a_r5_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_o && rd_en_o && mem_bias_o);
  // R5: done lasts a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6: readout enable never overlaps a running interval
  a_r6_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> !busy_o);
  // R7: captured lengths are held while running
  a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !seq_last) |=> $stable(ovh_q) && $stable(pre_q) && $stable(smp_q));

endmodule

// File: tb/fxfer_seq_tb.sv
module fxfer_seq_tb_top;
  localparam int unsigned W = 12;
  localparam int unsigned DEF_OVH = 659;
  localparam int unsigned MAXV = (32'd1 << W) - 32'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] ovh_len_i = '0, pre_len_i = '0, smp_len_i = '0;
  logic mem_bias_o, precharge_o, sample_o, busy_o, rd_en_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4ns clk = ~clk;

  fxfer_seq #(.W(W), .DEF_OVH(DEF_OVH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ovh_len_i(ovh_len_i), .pre_len_i(pre_len_i), .smp_len_i(smp_len_i),
    .mem_bias_o(mem_bias_o), .precharge_o(precharge_o), .sample_o(sample_o),
    .busy_o(busy_o), .rd_en_o(rd_en_o), .done_o(done_o)
  );

  function automatic logic [5:0] pack(logic b, logic p, logic s, logic bz, logic r, logic d);
    return {b, p, s, bz, r, d};
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp, int step);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s step %0d: actual {bias,pre,smp,busy,rd,done}=%b expected %b",
               req, step, act, exp);
    end
  endtask

  // Legal lengths restated from R8/R9
  task automatic legal(input int unsigned o, p, s, output int unsigned tl, pl, sl);
    int unsigned oo;
    pl = p;
    if (pl == 0) pl = 1;
    if (pl > MAXV - 2) pl = MAXV - 2;
    sl = s;
    if (sl <= pl) sl = pl + 1;
    if (sl > MAXV - 1) sl = MAXV - 1;
    oo = (o == 0) ? DEF_OVH : o;
    tl = (oo <= sl) ? sl + 1 : oo;
  endtask

  // One full transfer; optional stray start with junk lengths at step inj
  task automatic run_seq(string req, int unsigned o, p, s, int inj);
    int unsigned tl, pl, sl;
    legal(o, p, s, tl, pl, sl);
    @(negedge clk);
    ovh_len_i = W'(o); pre_len_i = W'(p); smp_len_i = W'(s);
    start_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= int'(tl) + 3; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (k == inj) begin
        start_i = 1'b1;
        ovh_len_i = W'(3); pre_len_i = W'(1); smp_len_i = W'(2);
      end
      if (k < int'(tl)) begin
        logic sh;
        sh = (k < int'(sl));
        check({req, " R3 R4 R5"}, pack(mem_bias_o, precharge_o, sample_o, busy_o, rd_en_o, done_o),
              pack(!sh, k < int'(pl), sh, 1'b1, 1'b0, 1'b0), k);
      end else begin
        check({req, " R5 R6"}, pack(mem_bias_o, precharge_o, sample_o, busy_o, rd_en_o, done_o),
              pack(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, k == int'(tl)), k);
      end
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset", pack(mem_bias_o, precharge_o, sample_o, busy_o, rd_en_o, done_o),
          pack(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 0);
  endtask

  task automatic t_entry;
    @(negedge clk);
    ovh_len_i = W'(20); pre_len_i = W'(3); smp_len_i = W'(7);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 R6 entry", pack(mem_bias_o, precharge_o, sample_o, busy_o, rd_en_o, done_o),
          pack(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0), 0);
    repeat (25) @(negedge clk);
    check("R1 idle", pack(mem_bias_o, precharge_o, sample_o, busy_o, rd_en_o, done_o),
          pack(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1ns rst_n = 1'b1;
    t_reset();
    t_entry();
    run_seq("normal", 40, 5, 12, -1);
    run_seq("R8 pre zero", 20, 0, 4, -1);
    run_seq("R8 smp<=pre", 20, 8, 8, -1);
    run_seq("R8 ovh<=smp", 10, 6, 12, -1);
    run_seq("R9 default ovh", 0, 20, 60, -1);
    run_seq("R8 R9 max pre", 0, MAXV, 0, -1);
    run_seq("R7 stray start", 30, 4, 9, 10);
    run_seq("R7 start at last step", 15, 2, 5, 14);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule